// File: doc/BRIEF.md
# External Memory Select and Wait-State Unit

This block sits between a processor core and a 14-bit external address bus. Each access request from the core carries a space code, an address and a read/write flag. The space code selects program, data, I/O or byte memory. The block drives one active-low select for each space and the read and write strobes. It also drives a composite select that follows any chosen subset of the individual selects.

Data addresses below 0x2000 pass through an overlay register. Depending on that register, they either stay inside the chip or go out to one of two external 8K pages. Every external access counts down a wait value from its own register. For I/O accesses, the wait value is picked by the address region. While the count runs, the block holds the core with `stall`.

The core keeps its request steady while `stall` is high. It may present the next request in the cycle after the last one completes. A small synchronous write port loads the configuration registers.

Top module: `extmem_sel`

## Requirements
- R1: Space code 0 drives `pms_n` low, 1 drives `dms_n` low (external data only), 2 drives `ioms_n` low and 3 drives `bms_n` low. At most one of these is low at a time, and all are high when no external access is requested.
- R2: `cms_n` is low in exactly the cycles in which some individual select is low and that select's enable bit is set. The enable bits are: bit 0 program, bit 1 data, bit 2 byte, bit 3 I/O.
- R3: After reset, the composite enable is 4'b1011, the overlay is 0 and every wait register holds 7.
- R4: An I/O access drives `ext_addr` to {3'b000, address bits 10:0}. Address bits 13:11 of the request are ignored.
- R5: The wait count of an I/O access comes from I/O wait register 0, 1, 2 or 3, selected by address bits 10:9.
- R6: A data access with the overlay at 0, or any data access to address 0x2000 or above, is internal. It asserts no select and no strobe, raises `int_hit` and completes without stall.
- R7: With the overlay at 1, a data access below 0x2000 is external with A13=0. With the overlay at 2, it is external with A13=1. In both cases A12:0 equal the request's low 13 bits.
- R8: Overlay values above 2 act as 0, so data accesses below 0x2000 stay internal.
- R9: An external access whose wait register holds W keeps `stall` high for exactly W cycles from its first cycle. It completes in W+1 cycles, so W=0 means a single cycle without stall.
- R10: When `cfg_we` is high on a clock edge, `cfg_addr` selects the register to load from the low bits of `cfg_wdata`:
  - 0: composite enable
  - 1: overlay (8 bits)
  - 2: program wait
  - 3: data wait
  - 4: byte wait
  - 5 to 8: I/O waits 0 to 3
- R11: During an external access, `rd_n` is low when `req_wr`=0 and `wr_n` is low when `req_wr`=1. Both are high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 4 | Configuration register index |
| cfg_wdata | input | 8 | Configuration write data |
| req_valid | input | 1 | Access request present |
| req_space | input | 2 | Space code: 0 program, 1 data, 2 I/O, 3 byte |
| req_addr | input | 14 | Request address |
| req_wr | input | 1 | 1 for write, 0 for read |
| ext_addr | output | 14 | External address bus |
| pms_n | output | 1 | Program select, active low |
| dms_n | output | 1 | Data select, active low |
| bms_n | output | 1 | Byte select, active low |
| ioms_n | output | 1 | I/O select, active low |
| cms_n | output | 1 | Composite select, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| stall | output | 1 | Holds the core until the access completes |
| int_hit | output | 1 | Data access served internally |

## Verification
Accesses are issued in every space under two composite-enable settings. This separates which select drives the composite pin from which select merely asserts. I/O requests go to one address in each of the four regions, with distinct wait values, and the upper address bits are set. Wrong region decoding or leaking high bits then shows up as a wrong stall length or address. Data requests are repeated at overlay values 0, 1, 2 and 3 and above 0x2000, which separates the internal, low-page, high-page and out-of-range paths. Wait values of 0, 1, 2 and 7 check the single-cycle case against the counted ones.

// File: rtl/extmem_sel.sv
module extmem_sel #(
  parameter int ADDR_W    = 14,
  parameter int IO_ADDR_W = 11,
  parameter int WAIT_W    = 3,
  parameter int CFG_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              req_valid,
  input  logic [1:0]        req_space,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wr,
  output logic [ADDR_W-1:0] ext_addr,
  output logic              pms_n,
  output logic              dms_n,
  output logic              bms_n,
  output logic              ioms_n,
  output logic              cms_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic              stall,
  output logic              int_hit
);

  localparam int PAGE_W  = ADDR_W - 1;
  localparam int IO_HI_W = ADDR_W - IO_ADDR_W;
  localparam logic [WAIT_W-1:0] WAIT_RST = '1;

  logic [3:0]        cs_en;
  logic [CFG_W-1:0]  ovl;
  logic [WAIT_W-1:0] wt_pm, wt_dm, wt_bm;
  logic [WAIT_W-1:0] wt_io [4];
  logic              busy;
  logic [WAIT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_en <= 4'b1011;
      ovl   <= '0;
      wt_pm <= WAIT_RST;
      wt_dm <= WAIT_RST;
      wt_bm <= WAIT_RST;
      for (int i = 0; i < 4; i++) wt_io[i] <= WAIT_RST;
    end else if (cfg_we) begin
      case (cfg_addr)
        4'd0: cs_en <= cfg_wdata[3:0];
        4'd1: ovl   <= cfg_wdata;
        4'd2: wt_pm <= cfg_wdata[WAIT_W-1:0];
        4'd3: wt_dm <= cfg_wdata[WAIT_W-1:0];
        4'd4: wt_bm <= cfg_wdata[WAIT_W-1:0];
        4'd5: wt_io[0] <= cfg_wdata[WAIT_W-1:0];
        4'd6: wt_io[1] <= cfg_wdata[WAIT_W-1:0];
        4'd7: wt_io[2] <= cfg_wdata[WAIT_W-1:0];
        4'd8: wt_io[3] <= cfg_wdata[WAIT_W-1:0];
        default: ;
      endcase
    end
  end

  wire is_pm   = req_space == 2'd0;
  wire is_dm   = req_space == 2'd1;
  wire is_io   = req_space == 2'd2;
  wire is_bm   = req_space == 2'd3;
  wire ovl_hi  = ovl == CFG_W'(2);
  wire ovl_ext = (ovl == CFG_W'(1)) || ovl_hi;
  wire dm_ext  = !req_addr[ADDR_W-1] && ovl_ext;
  wire act     = req_valid && !(is_dm && !dm_ext);
  wire [1:0] io_rgn = req_addr[IO_ADDR_W-1 -: 2];

  assign int_hit = req_valid && is_dm && !dm_ext;

  logic [3:0] sel;
  assign sel = act ? {is_io, is_bm, is_dm, is_pm} : 4'b0000;

  assign pms_n  = ~sel[0];
  assign dms_n  = ~sel[1];
  assign bms_n  = ~sel[2];
  assign ioms_n = ~sel[3];
  assign cms_n  = ~|(sel & cs_en);
  assign rd_n   = ~(act && !req_wr);
  assign wr_n   = ~(act && req_wr);

  always_comb begin
    ext_addr = '0;
    if (act) begin
      if (is_io)      ext_addr = {{IO_HI_W{1'b0}}, req_addr[IO_ADDR_W-1:0]};
      else if (is_dm) ext_addr = {ovl_hi, req_addr[PAGE_W-1:0]};
      else            ext_addr = req_addr;
    end
  end

  logic [WAIT_W-1:0] wsel;
  always_comb begin
    case (req_space)
      2'd0:    wsel = wt_pm;
      2'd1:    wsel = wt_dm;
      2'd2:    wsel = wt_io[io_rgn];
      default: wsel = wt_bm;
    endcase
  end

  wire start = act && !busy;
  assign stall = busy ? (cnt != '0) : (start && wsel != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end else if (start && wsel != '0) begin
      busy <= 1'b1;
      cnt  <= wsel - 1'b1;
    end
  end

  p_one_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~pms_n, ~dms_n, ~bms_n, ~ioms_n}));

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && !busy) |-> ({pms_n, dms_n, bms_n, ioms_n, cms_n} == 5'b11111));

  p_cms_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cms_n |-> !({pms_n, dms_n, bms_n, ioms_n} == 4'b1111));

  p_io_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ioms_n |-> (ext_addr[ADDR_W-1:IO_ADDR_W] == '0));

  p_int_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (int_hit && !busy) |-> (!stall && rd_n && wr_n && dms_n));

  p_count_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && rst_n) |-> (cnt == $past(cnt) - 1'b1));

  p_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_n == 1'b0 && wr_n == 1'b0));

endmodule

// File: tb/test_extmem_sel.sv
module test_extmem_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_space = '0;
  logic [13:0] req_addr = '0;
  logic        req_wr = 1'b0;
  logic [13:0] ext_addr;
  logic pms_n, dms_n, bms_n, ioms_n, cms_n, rd_n, wr_n, stall, int_hit;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  extmem_sel i_extmem_sel (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_space(req_space), .req_addr(req_addr), .req_wr(req_wr),
    .ext_addr(ext_addr), .pms_n(pms_n), .dms_n(dms_n), .bms_n(bms_n), .ioms_n(ioms_n),
    .cms_n(cms_n), .rd_n(rd_n), .wr_n(wr_n), .stall(stall), .int_hit(int_hit));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // esel: 0 pm, 1 dm, 2 bm, 3 io (bit order of {ioms_n,bms_n,dms_n,pms_n}), 4 = internal
  task automatic acc(input logic [1:0] sp, input logic [13:0] a, input logic w, input int esel,
                     input logic ecms, input logic [13:0] eaddr, input int ewait, input string tag);
    int n;
    logic [3:0] exp_sel;
    @(negedge clk);
    req_valid = 1'b1; req_space = sp; req_addr = a; req_wr = w;
    #1;
    exp_sel = (esel == 4) ? 4'hF : ~(4'b0001 << esel);
    chk({ioms_n, bms_n, dms_n, pms_n} == exp_sel, {tag, " R1 selects"}, {ioms_n, bms_n, dms_n, pms_n}, exp_sel);
    chk(cms_n == ecms, {tag, " R2 cms_n"}, cms_n, ecms);
    if (esel == 4) begin
      chk(int_hit == 1'b1, {tag, " R6 int_hit"}, int_hit, 1);
      chk({rd_n, wr_n} == 2'b11, {tag, " R6 strobes"}, {rd_n, wr_n}, 3);
    end else begin
      chk(ext_addr == eaddr, {tag, " address"}, ext_addr, eaddr);
      chk({rd_n, wr_n} == (w ? 2'b10 : 2'b01), {tag, " R11 strobes"}, {rd_n, wr_n}, (w ? 2 : 1));
    end
    n = 0;
    while (stall && n < 20) begin
      @(negedge clk); #1;
      n++;
    end
    chk(n == ewait, {tag, " R9 stall cycles"}, n, ewait);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk({pms_n, dms_n, bms_n, ioms_n, cms_n, stall} == 6'b111110, {tag, " R1 idle"},
        {pms_n, dms_n, bms_n, ioms_n, cms_n, stall}, 6'b111110);
  endtask

  task automatic t_reset;
    #1;
    chk({pms_n, dms_n, bms_n, ioms_n, cms_n} == 5'b11111, "R1 idle at reset", {pms_n, dms_n, bms_n, ioms_n, cms_n}, 5'h1F);
    acc(2'd0, 14'h1234, 1'b0, 0, 1'b0, 14'h1234, 7, "R3 reset prog");
    acc(2'd3, 14'h0055, 1'b1, 2, 1'b1, 14'h0055, 7, "R3 reset byte");
    acc(2'd2, 14'h0100, 1'b0, 3, 1'b0, 14'h0100, 7, "R3 reset io");
    acc(2'd1, 14'h0800, 1'b0, 4, 1'b1, 14'h0000, 0, "R3 reset data overlay 0");
  endtask

  task automatic t_cfg_spaces;
    cfg(4'd2, 8'd0);
    cfg(4'd3, 8'd2);
    cfg(4'd4, 8'd1);
    cfg(4'd0, 8'h04);
    acc(2'd0, 14'h2F00, 1'b1, 0, 1'b1, 14'h2F00, 0, "R10 prog wait 0");
    acc(2'd3, 14'h3FFF, 1'b0, 2, 1'b0, 14'h3FFF, 1, "R2 byte enabled");
    cfg(4'd0, 8'h01);
    acc(2'd0, 14'h0001, 1'b0, 0, 1'b0, 14'h0001, 0, "R2 prog enabled");
    acc(2'd3, 14'h0002, 1'b1, 2, 1'b1, 14'h0002, 1, "R2 byte disabled");
  endtask

  task automatic t_io;
    cfg(4'd5, 8'd1);
    cfg(4'd6, 8'd3);
    cfg(4'd7, 8'd5);
    cfg(4'd8, 8'd0);
    cfg(4'd0, 8'h08);
    acc(2'd2, 14'h3810, 1'b0, 3, 1'b0, 14'h0010, 1, "R5 io region0 R4");
    acc(2'd2, 14'h3A05, 1'b1, 3, 1'b0, 14'h0205, 3, "R5 io region1 R4");
    acc(2'd2, 14'h2450, 1'b0, 3, 1'b0, 14'h0450, 5, "R5 io region2");
    acc(2'd2, 14'h07FF, 1'b1, 3, 1'b0, 14'h07FF, 0, "R5 io region3");
    cfg(4'd0, 8'h01);
    acc(2'd2, 14'h0600, 1'b0, 3, 1'b1, 14'h0600, 0, "R2 io disabled");
  endtask

  task automatic t_overlay;
    cfg(4'd0, 8'h02);
    cfg(4'd1, 8'd1);
    acc(2'd1, 14'h1ABC, 1'b0, 1, 1'b0, 14'h1ABC, 2, "R7 overlay 1");
    cfg(4'd1, 8'd2);
    acc(2'd1, 14'h1ABC, 1'b1, 1, 1'b0, 14'h3ABC, 2, "R7 overlay 2");
    acc(2'd1, 14'h2100, 1'b0, 4, 1'b1, 14'h0000, 0, "R6 upper data internal");
    cfg(4'd1, 8'd3);
    acc(2'd1, 14'h0004, 1'b0, 4, 1'b1, 14'h0000, 0, "R8 overlay 3");
    cfg(4'd1, 8'h82);
    acc(2'd1, 14'h0004, 1'b1, 4, 1'b1, 14'h0000, 0, "R8 overlay 0x82");
    cfg(4'd1, 8'd0);
    acc(2'd1, 14'h1FFF, 1'b0, 4, 1'b1, 14'h0000, 0, "R6 overlay 0");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cfg_spaces();
    t_io();
    t_overlay();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule